// File: doc/BRIEF.md
# Maskable Eight-Source Interrupt Controller

This block gathers eight event inputs of equal rank into a single active-high interrupt line for a host processor. Each event input is a one-cycle pulse. The pulse latches into a sticky status bit. The interrupt line is raised while at least one latched bit has its mask bit open. The host reads the status register to learn which sources fired, and that read clears the bits it returned.

A single 16-bit enable register holds three things: the per-source mask, a 3-bit instruction-pointer match value and a 5-bit FIFO fill threshold. The last two are exported as outputs so that the blocks producing events 1 (pointer match) and 2 (FIFO threshold) can use them. Event 0 is the limit-crossing event. Its pulse is also passed straight out as a strobe that a neighbouring limit-detail register uses to latch.

A write to the enable register can raise events by accident, so software must read status once after every such write.

Top module: `irq_hub`

## Requirements
- R1: After reset the status register, the enable register, the exported match value and threshold, and the interrupt line are all zero.
- R2: A pulse on event input i sets status bit i whether or not mask bit i is open. A set bit stays set until a clearing read.
- R3: The interrupt line is a register. On each clock edge it takes the OR over all sources of (status bit AND mask bit), using the values those registers take at that same edge.
- R4: A read (host_re=1) at address 1 returns the status register on host_rdata[7:0] in the same cycle, with the upper bits zero. The read clears every status bit, and the interrupt line falls at that edge unless a new enabled event arrives.
- R5: An event pulse in the same cycle as a clearing status read leaves its bit set after the read.
- R6: A write (host_we=1) at address 0 loads the enable register with this layout: bits 7:0 are the mask (bit i for source i), bits 10:8 are the match value and bits 15:11 are the threshold. The match value and threshold appear on their outputs after the write edge, and a read at address 0 returns the whole register.
- R7: An event whose mask bit is closed never raises the interrupt line.
- R8: A write at address 1, 2 or 3 has no effect on any register. A read at address 0, 2 or 3 clears nothing. Reads at addresses 2 and 3 return zero, and host_rdata is zero whenever host_re is low.
- R9: The limit-latch strobe output equals event input 0 in the same cycle.
- R10: Opening the mask for a source whose status bit is already set raises the interrupt line at the edge of the enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 8 | One-cycle event pulses, bit i is source i |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe |
| host_addr | input | 2 | Register address: 0 enable, 1 status |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid in the cycle host_re is high |
| irq_o | output | 1 | Active-high interrupt line |
| match_ptr_o | output | 3 | Instruction-pointer match value for source 1 |
| fifo_thr_o | output | 5 | FIFO threshold for source 2 |
| lim_latch_o | output | 1 | Latch strobe for the limit-detail register |

## Verification
The bench first sends events with every mask bit closed. This separates the latching of status from the interrupt decision. Next it opens the mask over bits that are already pending, which shows that the line follows the newly written mask at the same edge. A status read that coincides with a fresh pulse tells a lost event apart from a kept one. Writes and reads at the wrong addresses show whether any stray access changes state. A long run of random pulses, writes and reads is then compared cycle by cycle with a queue-free reference model, which exposes errors in timing or in masking.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NSRC   = 8;
  localparam int PTR_W  = 3;
  localparam int THR_W  = 5;
  localparam int DATA_W = NSRC + PTR_W + THR_W;

  // enable register layout, msb first
  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic [PTR_W-1:0] ptr;
    logic [NSRC-1:0]  mask;
  } en_reg_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output en_reg_t           en_q,
  output en_reg_t           en_d
);
  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = en_reg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q == en_reg_t'($past(wdata))); // R6
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q)); // R8
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
  import irq_hub_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            rd_clr,
  output logic [NSRC-1:0] stat_q,
  output logic [NSRC-1:0] stat_d
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic keep;
    logic ce;

    always_comb begin
      keep      = rd_clr ? 1'b0 : stat_q[i];
      stat_d[i] = keep | evt[i];
      ce        = rd_clr | evt[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stat_q[i] <= 1'b0;
      else if (ce) stat_q[i] <= stat_d[i];
    end
  end

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (stat_q & $past(evt)) == $past(evt)); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> (stat_q & $past(stat_q)) == $past(stat_q)); // R2
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> stat_q == $past(evt)); // R4
endmodule

// File: rtl/irq_pin.sv
module irq_pin
  import irq_hub_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] stat_d,
  input  logic [NSRC-1:0] mask_d,
  output logic            irq_q
);
  logic irq_d;

  always_comb irq_d = |(stat_d & mask_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int EN_ADR  = 0,
  parameter int ST_ADR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq_o,
  output logic [PTR_W-1:0]  match_ptr_o,
  output logic [THR_W-1:0]  fifo_thr_o,
  output logic              lim_latch_o
);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(EN_ADR);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ST_ADR);

  logic            rst_sync_n;
  logic            en_wr;
  logic            st_clr;
  en_reg_t         en_q;
  en_reg_t         en_d;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] stat_d;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    en_wr  = host_we && (host_addr == A_EN);
    st_clr = host_re && (host_addr == A_ST);
  end

  irq_en_reg u_en (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (en_wr),
    .wdata (host_wdata),
    .en_q  (en_q),
    .en_d  (en_d)
  );

  irq_stat_reg u_stat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt    (evt_i),
    .rd_clr (st_clr),
    .stat_q (stat_q),
    .stat_d (stat_d)
  );

  irq_pin u_pin (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .stat_d (stat_d),
    .mask_d (en_d.mask),
    .irq_q  (irq_o)
  );

  always_comb begin
    host_rdata = '0;
    if (host_re) begin
      if (host_addr == A_EN)      host_rdata = DATA_W'(en_q);
      else if (host_addr == A_ST) host_rdata = DATA_W'(stat_q);
    end
  end

  assign match_ptr_o = en_q.ptr;
  assign fifo_thr_o  = en_q.thr;
  assign lim_latch_o = evt_i[0];

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == |(stat_q & en_q.mask)); // R3
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((stat_q & en_q.mask) == '0) |-> !irq_o); // R7
  AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_clr && evt_i == '0) |=> !irq_o); // R4
  AST_KEEP_RACE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_clr && (|evt_i)) |=> (stat_q != '0)); // R5
endmodule

// File: tb/tb_irq_hub.sv
`timescale 1ns/1ps
module tb_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  evt_i;
  logic        host_we, host_re;
  logic [1:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        irq_o;
  logic [2:0]  match_ptr_o;
  logic [4:0]  fifo_thr_o;
  logic        lim_latch_o;

  int total = 0;
  int bad   = 0;

  // reference state
  logic [7:0]  m_stat;
  logic [15:0] m_en;
  logic        m_irq;

  always #2.5 clk = ~clk;

  irq_hub dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_o(irq_o),
    .match_ptr_o(match_ptr_o), .fifo_thr_o(fifo_thr_o), .lim_latch_o(lim_latch_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic we, logic re, logic [1:0] a,
                      logic [15:0] wd, logic [7:0] ev);
    logic [15:0] exp_rd;
    @(negedge clk);
    evt_i = ev; host_we = we; host_re = re; host_addr = a; host_wdata = wd;
    #0.5;
    exp_rd = 16'h0;
    if (re && a == 2'd0) exp_rd = m_en;
    if (re && a == 2'd1) exp_rd = {8'h0, m_stat};
    chk(tag, "rdata", int'(host_rdata), int'(exp_rd));
    chk("R9", "lim_latch", int'(lim_latch_o), int'(ev[0]));
    @(posedge clk);
    if (we && a == 2'd0) m_en = wd;
    m_stat = ((re && a == 2'd1) ? 8'h0 : m_stat) | ev;
    m_irq  = |(m_stat & m_en[7:0]);
    #0.5;
    chk(tag, "irq", int'(irq_o), int'(m_irq));
    chk("R6", "match_ptr", int'(match_ptr_o), int'(m_en[10:8]));
    chk("R6", "fifo_thr", int'(fifo_thr_o), int'(m_en[15:11]));
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; host_we = 0; host_re = 0; host_addr = 0; host_wdata = 0;
    m_stat = 0; m_en = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 reset state
    #0.5;
    chk("R1", "irq", int'(irq_o), 0);
    chk("R1", "match_ptr", int'(match_ptr_o), 0);
    chk("R1", "fifo_thr", int'(fifo_thr_o), 0);
    step("R1", 1'b0, 1'b1, 2'd0, 16'h0, 8'h0);
    step("R1", 1'b0, 1'b0, 2'd1, 16'h0, 8'h0);
    // R2/R7: events with all masks closed
    step("R7", 1'b0, 1'b0, 2'd0, 16'h0, 8'h05);
    step("R7", 1'b0, 1'b0, 2'd0, 16'h0, 8'h80);
    idle("R2");
    step("R2", 1'b0, 1'b1, 2'd1, 16'h0, 8'h00);  // read returns 85, clears
    step("R4", 1'b0, 1'b1, 2'd1, 16'h0, 8'h00);  // now zero
    // R10: pending bit, then open mask
    step("R10", 1'b0, 1'b0, 2'd0, 16'h0, 8'h04);
    step("R10", 1'b1, 1'b0, 2'd0, {5'd17, 3'd3, 8'h05}, 8'h00);
    step("R6", 1'b0, 1'b1, 2'd0, 16'h0, 8'h00);
    // R4: clearing read drops the line
    step("R4", 1'b0, 1'b1, 2'd1, 16'h0, 8'h00);
    idle("R4");
    // R3: enabled event raises the line
    step("R3", 1'b0, 1'b0, 2'd0, 16'h0, 8'h01);
    idle("R3");
    // R5: event in the same cycle as the clearing read
    step("R5", 1'b0, 1'b1, 2'd1, 16'h0, 8'h04);
    step("R5", 1'b0, 1'b1, 2'd1, 16'h0, 8'h00);
    // R8: stray accesses
    step("R8", 1'b0, 1'b0, 2'd0, 16'h0, 8'h10);
    step("R8", 1'b1, 1'b0, 2'd1, 16'hFFFF, 8'h00);
    step("R8", 1'b1, 1'b0, 2'd2, 16'hFFFF, 8'h00);
    step("R8", 1'b1, 1'b1, 2'd3, 16'hFFFF, 8'h00);
    step("R8", 1'b0, 1'b1, 2'd2, 16'h0, 8'h00);
    step("R8", 1'b0, 1'b1, 2'd0, 16'h0, 8'h00);
    step("R8", 1'b0, 1'b1, 2'd1, 16'h0, 8'h00);
    // R6: mask variants
    step("R6", 1'b1, 1'b0, 2'd0, {5'd31, 3'd7, 8'hF0}, 8'h10);
    step("R6", 1'b0, 1'b1, 2'd0, 16'h0, 8'h00);
    step("R7", 1'b1, 1'b0, 2'd0, {5'd1, 3'd0, 8'h0F}, 8'h00);
    step("R4", 1'b0, 1'b1, 2'd1, 16'h0, 8'h00);
    // R3: random traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [7:0]  ev;
      logic [15:0] wd;
      logic        we, re;
      ev = (($urandom % 4) == 0) ? 8'($urandom) : 8'h0;
      wd = 16'($urandom);
      we = (($urandom % 8) == 0);
      re = (($urandom % 4) == 0);
      step("R3", we, re, 2'($urandom), wd, ev);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule